// File: doc/BRIEF.md
# Message Doorbell Receiver

This block terminates a region of memory-mapped doorbells, one 4 KiB page per interrupt file. A device signals an interrupt by writing a 32-bit word whose value is an interrupt identity to the first word of a page. The receiver checks the write's address, byte lanes and value. It turns each legal write into a one-cycle set-pending request that carries the page number and the identity. The interrupt file downstream then sets the pending bit and re-evaluates its interrupt output.

Any write that breaks a rule is dropped and raises a sticky error flag. The same applies to any read that is misaligned or out of range. Reads never return data: the read port acknowledges every read one cycle later with an all-zero word.

A three-state machine holds the outcome of the previous cycle's write:
- `ST_IDLE`: no write was seen.
- `ST_EMIT`: a legal write was accepted, and the set-pending pulse is driven.
- `ST_REJECT`: a write was dropped, and the error flag is set on the next edge.

Every state has the same transitions:
- `wr_valid` with a legal write moves to `ST_EMIT`.
- `wr_valid` with an illegal write moves to `ST_REJECT`.
- No `wr_valid` moves to `ST_IDLE`.

A write is therefore accepted on every cycle, and back-to-back writes are handled without stalls.

Top module: `msi_doorbell_rx`

## Requirements
- R1: A write is legal when all of these hold: the address is 4-byte aligned, the address is below NUM_PAGES*4096, the offset within the page is 0, all four byte enables are set, and the value lies in 1..NUM_IDS-1. A legal write sampled on edge k drives `sp_valid` high for exactly the cycle after edge k. In that cycle `sp_page` equals address bits [12 +: PAGE_W] and `sp_id` equals the data value, read little-endian so that `wr_data[7:0]` is the least significant byte.
- R2: A write whose address bits [1:0] are not 00 produces no pulse and sets the error flag.
- R3: A write whose address is NUM_PAGES*4096 or higher produces no pulse and sets the error flag.
- R4: An aligned, in-range write whose offset within its page (address bits [11:0]) is nonzero produces no pulse and sets the error flag.
- R5: A write whose byte enables `wr_be` are not all 1 (4'hF) produces no pulse and sets the error flag.
- R6: A write whose full 32-bit value is 0 or is NUM_IDS or higher produces no pulse and sets the error flag. No pulse ever carries identity 0 or an identity of NUM_IDS or higher.
- R7: A read sampled on edge k raises `rd_done` for the following cycle, with `rd_data` equal to 0. An aligned read below NUM_PAGES*4096 leaves the error flag clear, whatever its offset.
- R8: A read that is misaligned, or at NUM_PAGES*4096 or higher, sets the error flag one edge after `rd_done` rises.
- R9: The error flag, set on the edge after the cycle in which a bad access completes, stays set until `err_clr` is sampled high. If a set and a clear meet on the same edge, the set wins.
- R10: Writes on consecutive edges each give their own pulse in consecutive cycles, with their own page and identity.
- R11: While reset is asserted, and right after it, `sp_valid`, `rd_done` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data (identity, little-endian) |
| rd_valid | input | 1 | Read request this cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_done | output | 1 | Read acknowledge, one cycle after the request |
| rd_data | output | 32 | Read data, always zero |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky flag for any dropped access |
| sp_valid | output | 1 | One-cycle set-pending request |
| sp_page | output | PAGE_W | Page of the request |
| sp_id | output | ID_W | Identity of the request |

## Verification
The bench builds the receiver with NUM_PAGES=3 and NUM_IDS=48, neither a power of two. With these values the range limit at 0x3000 and the identity limit at 48 both fall inside the address and identity fields, not on a field edge. A page field value of 3 and identities 48 to 63 can therefore be written, and each must be rejected by a magnitude compare rather than by simply truncating a field. The default 4 KiB page keeps the offset field at 12 bits, so the bench can exercise offsets both inside a word (+1, +2) and beyond the first word (+4, +0x800).

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;

    // Outcome of the previous cycle's write
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_REJECT = 2'd2
    } rx_state_e;

    // Classification of one write, first failing rule wins
    typedef enum logic [2:0] {
        V_OK       = 3'd0,
        V_MISALIGN = 3'd1,
        V_RANGE    = 3'd2,
        V_WIDTH    = 3'd3,
        V_OFFSET   = 3'd4,
        V_IDENT    = 3'd5
    } verdict_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/msi_addr_check.sv
module msi_addr_check #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned NUM_PAGES  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              aligned,
    output logic              in_range
);
    localparam logic [ADDR_W:0] REGION_END = (ADDR_W+1)'(NUM_PAGES << PAGE_SHIFT);

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        in_range = ({1'b0, addr} < REGION_END);
    end
endmodule

// File: rtl/msi_id_check.sv
module msi_id_check #(
    parameter int unsigned NUM_IDS = 64,
    parameter int unsigned ID_W    = 6
) (
    input  logic [31:0]     data,
    output logic            id_ok,
    output logic [ID_W-1:0] id
);
    always_comb begin
        id_ok = (data != 32'd0) && (data < 32'(NUM_IDS));
        id    = data[ID_W-1:0];
    end
endmodule

// File: rtl/msi_err_flag.sv
module msi_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R9: a set flag survives until a clear is sampled
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag) && !$past(clr)) |-> flag);

    // R9: a set beats a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set) |-> flag);
endmodule

// File: rtl/msi_doorbell_rx.sv
module msi_doorbell_rx
    import msi_rx_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned NUM_PAGES  = 4,
    parameter int unsigned NUM_IDS    = 64,
    localparam int unsigned PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int unsigned ID_W      = $clog2(NUM_IDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_done,
    output logic [31:0]       rd_data,
    input  logic              err_clr,
    output logic              err_flag,
    output logic              sp_valid,
    output logic [PAGE_W-1:0] sp_page,
    output logic [ID_W-1:0]   sp_id
);
    localparam int unsigned N_PORTS = 2;   // index 0: write, 1: read

    rx_state_e          state_q, state_d;
    verdict_e           verdict;
    logic [ADDR_W-1:0]  port_addr     [N_PORTS];
    logic               port_aligned  [N_PORTS];
    logic               port_in_range [N_PORTS];
    logic               id_ok;
    logic [ID_W-1:0]    id_val;
    logic [PAGE_W-1:0]  page_q;
    logic [ID_W-1:0]    id_q;
    logic               rd_done_q;
    logic               rd_bad_q;
    logic               err_set;

    always_comb begin
        port_addr[0] = wr_addr;
        port_addr[1] = rd_addr;
    end

    // Same alignment and range rules on both ports
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        msi_addr_check #(
            .ADDR_W     (ADDR_W),
            .PAGE_SHIFT (PAGE_SHIFT),
            .NUM_PAGES  (NUM_PAGES)
        ) u_chk (
            .addr     (port_addr[p]),
            .aligned  (port_aligned[p]),
            .in_range (port_in_range[p])
        );
    end

    msi_id_check #(
        .NUM_IDS (NUM_IDS),
        .ID_W    (ID_W)
    ) u_id (
        .data  (wr_data),
        .id_ok (id_ok),
        .id    (id_val)
    );

    // Write classification
    always_comb begin
        if (!port_aligned[0])                       verdict = V_MISALIGN;
        else if (!port_in_range[0])                 verdict = V_RANGE;
        else if (wr_be != 4'hF)                     verdict = V_WIDTH;
        else if (wr_addr[PAGE_SHIFT-1:0] != '0)     verdict = V_OFFSET;
        else if (!id_ok)                            verdict = V_IDENT;
        else                                        verdict = V_OK;
    end

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_EMIT, ST_REJECT: begin
                if (wr_valid) state_d = (verdict == V_OK) ? ST_EMIT : ST_REJECT;
                else          state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured request and read bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q    <= '0;
            id_q      <= '0;
            rd_done_q <= 1'b0;
            rd_bad_q  <= 1'b0;
        end else begin
            if (wr_valid && verdict == V_OK) begin
                page_q <= wr_addr[PAGE_SHIFT +: PAGE_W];
                id_q   <= id_val;
            end
            rd_done_q <= rd_valid;
            rd_bad_q  <= rd_valid && !(port_aligned[1] && port_in_range[1]);
        end
    end

    // Outputs
    always_comb begin
        sp_valid = (state_q == ST_EMIT);
        sp_page  = page_q;
        sp_id    = id_q;
        rd_done  = rd_done_q;
        rd_data  = '0;
        err_set  = (state_q == ST_REJECT) || rd_bad_q;
    end

    msi_err_flag u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (err_clr),
        .flag  (err_flag)
    );

    // R1: every pulse is caused by a write on the previous edge
    a_r1_pulse_has_write: assert property (@(posedge clk) disable iff (!rst_n)
        sp_valid |-> $past(wr_valid));

    // R2: misaligned write never pulses
    a_r2_misaligned_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_valid && wr_addr[1:0] != 2'b00) |-> !sp_valid);

    // R3: pulse page always inside configured pages
    a_r3_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sp_valid |-> (32'(sp_page) < 32'(NUM_PAGES)));

    // R4: nonzero page offset never pulses
    a_r4_offset_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_valid && wr_addr[PAGE_SHIFT-1:0] != '0) |-> !sp_valid);

    // R5: partial byte enables never pulse
    a_r5_partial_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_valid && wr_be != 4'hF) |-> !sp_valid);

    // R6: pulsed identity is legal
    a_r6_id_legal: assert property (@(posedge clk) disable iff (!rst_n)
        sp_valid |-> (sp_id != '0 && 32'(sp_id) < 32'(NUM_IDS)));

    // R7: every read is acknowledged on the next cycle
    a_r7_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_done);

    // R8: error follows a misaligned read
    a_r8_bad_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_done && rd_bad_q) |-> err_flag);
endmodule

// File: tb/msi_doorbell_rx_bench.sv
`timescale 1ns/1ps
module msi_doorbell_rx_bench;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned NPG    = 3;
    localparam int unsigned NID    = 48;
    localparam int unsigned PW     = 2;
    localparam int unsigned IW     = 6;
    localparam int          NVEC   = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [3:0]        wr_be = 4'hF;
    logic [31:0]       wr_data = '0;
    logic              rd_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_done;
    logic [31:0]       rd_data;
    logic              err_clr = 1'b0;
    logic              err_flag;
    logic              sp_valid;
    logic [PW-1:0]     sp_page;
    logic [IW-1:0]     sp_id;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    msi_doorbell_rx #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(12), .NUM_PAGES(NPG), .NUM_IDS(NID)
    ) u_msi_doorbell_rx (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
        .err_clr(err_clr), .err_flag(err_flag),
        .sp_valid(sp_valid), .sp_page(sp_page), .sp_id(sp_id)
    );

    // Stimulus / expectation table
    localparam logic [15:0] T_ADDR [NVEC] = '{16'h0000, 16'h2000, 16'h1000, 16'h2002, 16'h1001,
        16'h3000, 16'hF000, 16'h1004, 16'h1800, 16'h1000, 16'h1000, 16'h1000, 16'h1000};
    localparam logic [3:0]  T_BE   [NVEC] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF,
        4'hF, 4'hF, 4'h7, 4'hF, 4'hF, 4'hF};
    localparam logic [31:0] T_DATA [NVEC] = '{32'd1, 32'd47, 32'h20, 32'd5, 32'd5, 32'd5,
        32'd5, 32'd5, 32'd5, 32'd5, 32'd0, 32'd48, 32'h0100_0005};
    localparam logic        T_FIRE [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [1:0]  T_PAGE [NVEC] = '{2'd0, 2'd2, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0,
        2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
    localparam logic [5:0]  T_ID   [NVEC] = '{6'd1, 6'd47, 6'd32, 6'd0, 6'd0, 6'd0, 6'd0,
        6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0};
    localparam logic [15:0] T_REQ  [NVEC] = '{"R1", "R1", "R1", "R2", "R2", "R3", "R3",
        "R4", "R4", "R5", "R6", "R6", "R6"};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0; wr_be = 4'hF;
    endtask

    task automatic do_read(input logic [15:0] a);
        rd_valid = 1'b1; rd_addr = a;
        @(posedge clk); @(negedge clk);
        rd_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11", "sp_valid in reset", 32'(sp_valid), 32'd0);
        chk("R11", "err_flag in reset", 32'(err_flag), 32'd0);
        chk("R11", "rd_done in reset", 32'(rd_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "sp_valid after reset", 32'(sp_valid), 32'd0);
        chk("R11", "err_flag after reset", 32'(err_flag), 32'd0);

        // Table walk: R1..R6
        for (int i = 0; i < NVEC; i++) begin
            do_write(T_ADDR[i], T_BE[i], T_DATA[i]);
            chk($sformatf("%s", T_REQ[i]), $sformatf("vec %0d sp_valid", i),
                32'(sp_valid), 32'(T_FIRE[i]));
            if (T_FIRE[i]) begin
                chk($sformatf("%s", T_REQ[i]), $sformatf("vec %0d sp_page", i),
                    32'(sp_page), 32'(T_PAGE[i]));
                chk($sformatf("%s", T_REQ[i]), $sformatf("vec %0d sp_id", i),
                    32'(sp_id), 32'(T_ID[i]));
            end
            @(posedge clk); @(negedge clk);
            chk($sformatf("%s", T_REQ[i]), $sformatf("vec %0d pulse width", i),
                32'(sp_valid), 32'd0);
            chk($sformatf("%s", T_REQ[i]), $sformatf("vec %0d err_flag", i),
                32'(err_flag), 32'(!T_FIRE[i]));
            clear_err();
        end

        // R10: back-to-back legal writes
        wr_valid = 1'b1; wr_addr = 16'h1000; wr_data = 32'd7;
        @(posedge clk); @(negedge clk);
        chk("R10", "first sp_valid", 32'(sp_valid), 32'd1);
        chk("R10", "first sp_id", 32'(sp_id), 32'd7);
        chk("R10", "first sp_page", 32'(sp_page), 32'd1);
        wr_addr = 16'h2000; wr_data = 32'd9;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0;
        chk("R10", "second sp_valid", 32'(sp_valid), 32'd1);
        chk("R10", "second sp_id", 32'(sp_id), 32'd9);
        chk("R10", "second sp_page", 32'(sp_page), 32'd2);
        @(posedge clk); @(negedge clk);
        chk("R10", "idle after burst", 32'(sp_valid), 32'd0);
        chk("R10", "no error after burst", 32'(err_flag), 32'd0);

        // R7: legal reads, including nonzero offset
        do_read(16'h1000);
        chk("R7", "rd_done", 32'(rd_done), 32'd1);
        chk("R7", "rd_data", rd_data, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R7", "rd_done width", 32'(rd_done), 32'd0);
        chk("R7", "err after good read", 32'(err_flag), 32'd0);
        do_read(16'h2004);
        chk("R7", "offset read rd_data", rd_data, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R7", "err after offset read", 32'(err_flag), 32'd0);

        // R8: bad reads
        do_read(16'h1003);
        chk("R8", "misaligned rd_done", 32'(rd_done), 32'd1);
        chk("R8", "misaligned rd_data", rd_data, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R8", "err after misaligned read", 32'(err_flag), 32'd1);
        clear_err();
        do_read(16'h3000);
        @(posedge clk); @(negedge clk);
        chk("R8", "err after out-of-range read", 32'(err_flag), 32'd1);
        clear_err();
        chk("R9", "clear takes effect", 32'(err_flag), 32'd0);

        // R9: sticky
        do_write(16'h0002, 4'hF, 32'd3);
        repeat (4) begin @(posedge clk); @(negedge clk); end
        chk("R9", "flag sticky", 32'(err_flag), 32'd1);
        clear_err();
        chk("R9", "cleared", 32'(err_flag), 32'd0);

        // R9: set wins over clear on the same edge
        do_write(16'h3000, 4'hF, 32'd3);
        err_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        err_clr = 1'b0;
        chk("R9", "set beats clear", 32'(err_flag), 32'd1);
        clear_err();
        chk("R9", "final clear", 32'(err_flag), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule